// File: doc/BRIEF.md
# Shadow-Backed Static Memory with Store and Recall

This block models a 2048-word by 8-bit static memory in which every word has a nonvolatile shadow copy. A host drives active-low chip-enable, output-enable, write-enable and nonvolatile-enable pins. These pins are brought into the clock domain through two-flop synchronisers. With nonvolatile-enable high, the block behaves as an ordinary RAM. With chip-enable and nonvolatile-enable both low, it accepts whole-array transfers. A STORE copies every working word into the shadow array. A RECALL first zeroes the working array and then copies the shadow array back into it.

A RECALL starts on its own when reset is released. It can also be started by a pulse on a dedicated hardware recall input. While any transfer runs, a busy output is high and every host read and write is ignored. Each transfer moves one word per clock. The word order follows a row/column split of the address: the row comes from bits 9..5, and the column from bit 10 together with bits 4..0.

Top module: `nv_shadow_ram`

## Requirements
- R1: While reset is asserted and after it is released, busy is high and data_oe is low. After release, busy stays high for exactly 4096 clock cycles, which is the automatic recall.
- R2: With ce_n high the block is in standby. data_oe stays low and no word is written, whatever we_n and oe_n do.
- R3: With ce_n low, nv_n high and we_n high, data_oe is high only when oe_n is low. In that case data_o carries the addressed word. With oe_n high, data_oe stays low.
- R4: With ce_n low, nv_n high and we_n low, data_i is written to the addressed word for either level of oe_n, and data_oe stays low.
- R5: A new assertion of we_n low while ce_n and nv_n are low starts a STORE. Busy is then high for exactly 2048 cycles, and afterwards the shadow array holds a copy of the working array.
- R6: A new assertion of oe_n low with we_n high, while ce_n and nv_n are low, starts a RECALL. Busy is then high for exactly 4096 cycles, and afterwards every working word equals its shadow word.
- R7: A rising edge on recall_req starts the same RECALL as R6.
- R8: A RECALL leaves the shadow array unchanged, so repeated RECALLs restore the same contents.
- R9: While busy is high, host reads and writes are ignored. data_oe stays low and no host data reaches the working array.
- R10: If a STORE request and a hardware recall request arrive in the same sampled cycle, the STORE runs and the recall request is dropped. Requests that arrive during a transfer are also dropped.
- R11: A request held asserted starts only one transfer. Afterwards the block returns to idle and busy stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset (power-up) |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low; recall request in nonvolatile mode |
| we_n | input | 1 | Write enable, active low; store request in nonvolatile mode |
| nv_n | input | 1 | Nonvolatile mode select, active low |
| recall_req | input | 1 | Hardware recall request, rising-edge triggered |
| addr | input | 11 | Word address |
| data_i | input | 8 | Write data |
| data_o | output | 8 | Read data |
| data_oe | output | 1 | High when data_o should drive the bus |
| busy | output | 1 | High while a STORE or RECALL runs |

## Verification
Two transfer requests can land in the same sampled cycle: a STORE request from the pins and a hardware recall pulse. The bench changes both inputs in one assignment, so they cross the synchronisers together. It then judges the result in two ways. The busy window must last 2048 cycles, with no recall chained after it. A later RECALL must bring back the word written just before the collision, which shows that the STORE took effect. The bench also overlaps host reads and writes with a running STORE, and checks that neither one leaks through.

// File: rtl/nv_shadow_ram.sv
module nv_shadow_ram #(
  parameter int AW     = 11,
  parameter int DW     = 8,
  parameter int COL_LO = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ce_n,
  input  logic          oe_n,
  input  logic          we_n,
  input  logic          nv_n,
  input  logic          recall_req,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] data_i,
  output logic [DW-1:0] data_o,
  output logic          data_oe,
  output logic          busy
);
  localparam int DEPTH = 1 << AW;
  localparam logic [AW-1:0] LAST = '1;
  localparam logic [4:0] PINS_IDLE = 5'b01111;

  typedef enum logic [1:0] {ST_IDLE, ST_CLEAR, ST_LOAD, ST_SAVE} state_t;

  logic [DW-1:0] work   [DEPTH];
  logic [DW-1:0] shadow [DEPTH];

  logic [4:0] s1, s2;
  state_t state;
  logic [AW-1:0] cnt;
  logic save_q, load_q, hw_q;

  function automatic logic [AW-1:0] phys(input logic [AW-1:0] a);
    return {a[AW-2:COL_LO], a[AW-1], a[COL_LO-1:0]};
  endfunction

  wire ce  = ~s2[0];
  wire oe  = ~s2[1];
  wire we  = ~s2[2];
  wire nvm = ~s2[3];
  wire hw  = s2[4];

  wire idle     = (state == ST_IDLE);
  wire save_rq  = ce & nvm & we;
  wire load_rq  = ce & nvm & oe & ~we;
  wire ram_rd   = idle & ce & ~nvm & ~we;
  wire ram_wr   = idle & ce & ~nvm & we;

  wire go_save  = idle & save_rq & ~save_q;
  wire go_load  = idle & ~go_save & ((load_rq & ~load_q) | (hw & ~hw_q));

  assign busy = ~idle;

  logic          w_en;
  logic [AW-1:0] w_idx;
  logic [DW-1:0] w_dat;

  always_comb begin
    w_en  = 1'b0;
    w_idx = cnt;
    w_dat = '0;
    case (state)
      ST_CLEAR: w_en = 1'b1;
      ST_LOAD: begin
        w_en  = 1'b1;
        w_dat = shadow[cnt];
      end
      ST_IDLE: if (ram_wr) begin
        w_en  = 1'b1;
        w_idx = phys(addr);
        w_dat = data_i;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (w_en) work[w_idx] <= w_dat;
    if (state == ST_SAVE) shadow[cnt] <= work[cnt];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1      <= PINS_IDLE;
      s2      <= PINS_IDLE;
      state   <= ST_CLEAR;
      cnt     <= '0;
      save_q  <= 1'b0;
      load_q  <= 1'b0;
      hw_q    <= 1'b0;
      data_o  <= '0;
      data_oe <= 1'b0;
    end else begin
      s1     <= {recall_req, nv_n, we_n, oe_n, ce_n};
      s2     <= s1;
      save_q <= save_rq;
      load_q <= load_rq;
      hw_q   <= hw;
      data_oe <= ram_rd & oe;
      if (ram_rd) data_o <= work[phys(addr)];
      case (state)
        ST_IDLE: begin
          cnt <= '0;
          if (go_save)      state <= ST_SAVE;
          else if (go_load) state <= ST_CLEAR;
        end
        ST_CLEAR: begin
          cnt <= cnt + 1'b1;
          if (cnt == LAST) state <= ST_LOAD;
        end
        default: begin
          cnt <= cnt + 1'b1;
          if (cnt == LAST) state <= ST_IDLE;
        end
      endcase
    end
  end
endmodule

// File: rtl/nv_shadow_ram_chk.sv
module nv_shadow_ram_chk #(
  parameter int AW = 11
) (
  input logic clk,
  input logic rst_n,
  input logic ce_n,
  input logic oe_n,
  input logic we_n,
  input logic nv_n,
  input logic data_oe,
  input logic busy
);
  localparam int DEPTH = 1 << AW;

  logic [AW+1:0] run;
  logic [2:0]    age;
  logic          first_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run     <= '0;
      age     <= '0;
      first_q <= 1'b0;
    end else begin
      run     <= busy ? run + 1'b1 : '0;
      if (age != 3'd4) age <= age + 1'b1;
      first_q <= 1'b1;
    end
  end

  // R1
  powerup_recall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !first_q |-> busy && !data_oe);

  // R5 R6
  transfer_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (run == (AW+2)'(DEPTH) || run == (AW+2)'(2*DEPTH)));

  // R9
  busy_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && $past(busy) |-> !data_oe);

  // R3
  drive_only_on_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (age == 3'd4) && data_oe |->
      !$past(ce_n, 3) && $past(nv_n, 3) && $past(we_n, 3) && !$past(oe_n, 3));
endmodule

bind nv_shadow_ram nv_shadow_ram_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
  .nv_n(nv_n), .data_oe(data_oe), .busy(busy)
);

// File: tb/sim_nv_shadow_ram.sv
`timescale 1ns/1ps
module sim_nv_shadow_ram;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1, nv_n = 1'b1, recall_req = 1'b0;
  logic [10:0] addr = '0;
  logic [7:0]  data_i = '0;
  logic [7:0]  data_o;
  logic        data_oe, busy;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  nv_shadow_ram u0 (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .nv_n(nv_n), .recall_req(recall_req), .addr(addr), .data_i(data_i),
    .data_o(data_o), .data_oe(data_oe), .busy(busy)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic standby();
    ce_n = 1'b1; oe_n = 1'b1; we_n = 1'b1; nv_n = 1'b1;
    cyc(4);
  endtask

  task automatic wr(input logic [10:0] a, input logic [7:0] d, input logic oe);
    addr = a; data_i = d; nv_n = 1'b1; oe_n = oe; we_n = 1'b0; ce_n = 1'b0;
    cyc(5);
    chk(data_oe == 1'b0, "R4 oe during write", data_oe, 0);
    standby();
  endtask

  task automatic rd(input logic [10:0] a, input logic [7:0] e, input string tag);
    addr = a; nv_n = 1'b1; we_n = 1'b1; oe_n = 1'b0; ce_n = 1'b0;
    cyc(5);
    chk(data_oe == 1'b1 && data_o == e, tag, data_o, e);
    standby();
  endtask

  task automatic busy_len(output int n);
    int w = 0;
    n = 0;
    while (!busy && w < 20) begin w++; @(negedge clk); end
    while (busy && n < 10000) begin n++; @(negedge clk); end
  endtask

  task automatic stays_idle(input string tag);
    int hi = 0;
    for (int i = 0; i < 12; i++) begin
      if (busy) hi++;
      @(negedge clk);
    end
    chk(hi == 0, tag, hi, 0);
  endtask

  task automatic nv_recall(input string tag);
    int n;
    ce_n = 1'b0; nv_n = 1'b0; we_n = 1'b1; oe_n = 1'b0;
    busy_len(n);
    chk(n == 4096, tag, n, 4096);
    standby();
  endtask

  task automatic t_powerup();
    cyc(3);
    chk(busy == 1'b1 && data_oe == 1'b0, "R1 in reset", {busy, data_oe}, 2);
    rst_n = 1'b1;
    begin
      int n = 0;
      while (busy && n < 10000) begin n++; @(negedge clk); end
      chk(n == 4096, "R1 powerup recall length", n, 4096);
    end
  endtask

  task automatic t_rw();
    wr(11'h000, 8'h3C, 1'b1);
    wr(11'h7FF, 8'hC3, 1'b0);
    wr(11'h421, 8'h5A, 1'b1);
    wr(11'h0A5, 8'hA5, 1'b0);
    rd(11'h000, 8'h3C, "R3 read 000");
    rd(11'h7FF, 8'hC3, "R4 write with oe low");
    rd(11'h421, 8'h5A, "R3 read 421");
    rd(11'h0A5, 8'hA5, "R4 read 0A5");
  endtask

  task automatic t_standby();
    addr = 11'h000; data_i = 8'hFF;
    ce_n = 1'b1; nv_n = 1'b1; we_n = 1'b0; oe_n = 1'b0;
    cyc(6);
    chk(data_oe == 1'b0, "R2 standby no drive", data_oe, 0);
    standby();
    rd(11'h000, 8'h3C, "R2 standby no write");
    ce_n = 1'b0; nv_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
    cyc(6);
    chk(data_oe == 1'b0, "R3 internal read no drive", data_oe, 0);
    standby();
  endtask

  task automatic t_store();
    int n;
    ce_n = 1'b0; nv_n = 1'b0; we_n = 1'b0; oe_n = 1'b1;
    busy_len(n);
    chk(n == 2048, "R5 store length", n, 2048);
    stays_idle("R11 held store no repeat");
    standby();
  endtask

  task automatic t_recall_nv();
    wr(11'h000, 8'h11, 1'b1);
    wr(11'h421, 8'h22, 1'b1);
    nv_recall("R6 recall length");
    rd(11'h000, 8'h3C, "R6 restored 000");
    rd(11'h421, 8'h5A, "R6 restored 421");
    rd(11'h7FF, 8'hC3, "R6 restored 7FF");
  endtask

  task automatic t_recall_hw();
    int n;
    wr(11'h0A5, 8'h77, 1'b0);
    recall_req = 1'b1;
    busy_len(n);
    chk(n == 4096, "R7 hw recall length", n, 4096);
    stays_idle("R11 held hw request no repeat");
    recall_req = 1'b0;
    cyc(4);
    rd(11'h0A5, 8'hA5, "R7 hw recall restored");
    wr(11'h7FF, 8'h99, 1'b1);
    recall_req = 1'b1;
    busy_len(n);
    recall_req = 1'b0;
    cyc(4);
    rd(11'h7FF, 8'hC3, "R8 shadow unchanged by recall");
  endtask

  task automatic t_busy_ignore();
    int w = 0;
    ce_n = 1'b0; nv_n = 1'b0; we_n = 1'b0; oe_n = 1'b1;
    while (!busy && w < 20) begin w++; @(negedge clk); end
    cyc(5);
    addr = 11'h000; data_i = 8'hEE;
    nv_n = 1'b1; we_n = 1'b1; oe_n = 1'b0;
    cyc(8);
    chk(data_oe == 1'b0, "R9 read blocked while busy", data_oe, 0);
    we_n = 1'b0;
    cyc(8);
    ce_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
    w = 0;
    while (busy && w < 10000) begin w++; @(negedge clk); end
    cyc(4);
    rd(11'h000, 8'h3C, "R9 write blocked while busy");
  endtask

  task automatic t_collision();
    int n;
    wr(11'h000, 8'h5D, 1'b1);
    ce_n = 1'b0; nv_n = 1'b0; we_n = 1'b0; oe_n = 1'b1; recall_req = 1'b1;
    busy_len(n);
    chk(n == 2048, "R10 store wins collision", n, 2048);
    stays_idle("R10 recall dropped");
    recall_req = 1'b0;
    standby();
    wr(11'h000, 8'h66, 1'b1);
    nv_recall("R10 recall after collision");
    rd(11'h000, 8'h5D, "R10 store took effect");
  endtask

  initial begin
    #(200000 * 5);
    chk(1'b0, "watchdog", 0, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_powerup();
    t_rw();
    t_standby();
    t_store();
    t_recall_nv();
    t_recall_hw();
    t_busy_ignore();
    t_collision();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule